// File: doc/BRIEF.md
# Audio Decoder Playback Sequencer

This block sequences a compressed-audio decoder core through three operating states: idle, init and decode. After any reset it waits in idle while configuration is written. A run command moves it to init, where the datapath fills its pipeline. When the datapath reports that its first decoded samples have reached the output stage, the block enters decode.

In decode, two register bits, PLAY and MUTE, select one of four behaviours. The block drives the output-clock enable, the decode enable and a zero-forcing select for the PCM path. PLAY and MUTE are sampled on the clock edge that completes init, and changes made during init have no effect.

A separate hysteresis generator watches the input buffer level. It drives a data-request line to the upstream bitstream source, whose active level is set by a configuration bit. This lets the source be throttled by buffer fill.

Top module: `playctl_top`

## Requirements
- R1: After hardware reset, state_o is 0 (idle), oclk_en=0, dec_en=0, pcm_zero=1, and the internal request is inactive, so data_req equals NOT req_pol.
- R2: In idle, run_cmd=1 moves state_o to 1 (init) on the next clock. Without run_cmd the block stays in idle.
- R3: In init, first_samples=1 moves state_o to 2 (decode) on the next clock. Otherwise the block stays in init.
- R4: While state_o is 0 or 1, oclk_en=0, dec_en=0 and pcm_zero=1, whatever PLAY and MUTE are.
- R5: PLAY and MUTE changes during init have no effect. The values that take effect are those present on the clock edge that moves the block into decode.
- R6: In decode, the outputs follow the effective PLAY/MUTE values:
  - (0,0): oclk_en=0, dec_en=0, pcm_zero=1.
  - (0,1): oclk_en=1, dec_en=0, pcm_zero=1.
  - (1,0): oclk_en=1, dec_en=1, pcm_zero=0.
  - (1,1): oclk_en=1, dec_en=1, pcm_zero=1.
- R7: In decode, a PLAY or MUTE change is reflected on the outputs one clock later.
- R8: soft_rst=1 returns the block to idle on the next clock from any state. It also clears the effective PLAY and MUTE values to 0.
- R9: The internal request becomes active one clock after buf_level < LOW_MARK. It becomes inactive one clock after buf_level > HIGH_MARK. Between the two marks, inclusive, it holds its value.
- R10: data_req equals the internal request when req_pol=1 and its inverse when req_pol=0. A polarity change shows on data_req without waiting for a clock.
- R11: Once in decode, the block stays there until a hardware or software reset. run_cmd and first_samples have no effect in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset to idle |
| run_cmd | input | 1 | Run command, leaves idle |
| first_samples | input | 1 | First decoded samples at the output stage |
| play_bit | input | 1 | PLAY register bit |
| mute_bit | input | 1 | MUTE register bit |
| buf_level | input | LVL_W | Input buffer occupancy |
| req_pol | input | 1 | 1: data_req active high, 0: active low |
| state_o | output | 2 | 0 idle, 1 init, 2 decode |
| oclk_en | output | 1 | Output audio clock enable |
| dec_en | output | 1 | Decoding enable |
| pcm_zero | output | 1 | 1 forces PCM output to zero |
| data_req | output | 1 | Request to the bitstream source |

## Verification
The hardest case is showing that PLAY and MUTE are ignored during init. Nothing on the ports changes while init lasts, so the bench toggles both bits through several cycles of init. It then presents a different pair on the exact edge where first_samples is high, and checks that decode reflects only that last pair.

A second hard case is showing that the soft reset clears the effective values. The bench walks the block back through init with PLAY=0 and MUTE=1, which would look the same if stale values survived without the clear. The request hysteresis is driven exactly onto both marks and one step past each, to pin the strict comparisons.

// File: rtl/playctl_pkg.sv
package playctl_pkg;

  typedef enum logic [1:0] {
    PC_IDLE   = 2'd0,
    PC_INIT   = 2'd1,
    PC_DECODE = 2'd2
  } pc_state_e;

  typedef struct packed {
    logic play;
    logic mute;
  } pc_cfg_t;

  // Output clocks run when either bit is set.
  function automatic logic pc_clk_run(pc_cfg_t c);
    return c.play | c.mute;
  endfunction

  // The decoding engine runs only with PLAY set.
  function automatic logic pc_decoding(pc_cfg_t c);
    return c.play;
  endfunction

  // Decoded samples pass only for PLAY=1, MUTE=0.
  function automatic logic pc_silence(pc_cfg_t c);
    return !(c.play && !c.mute);
  endfunction

endpackage

// File: rtl/playctl_seq.sv
module playctl_seq
  import playctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      soft_rst,
  input  logic      run_cmd,
  input  logic      first_samples,
  input  logic      play_bit,
  input  logic      mute_bit,
  output pc_state_e state,
  output pc_cfg_t   cfg,
  output logic      enter_init,
  output logic      enter_decode
);

  pc_state_e state_nx;
  pc_cfg_t   cfg_nx;

  assign enter_init   = !soft_rst && (state == PC_IDLE) && run_cmd;
  assign enter_decode = !soft_rst && (state == PC_INIT) && first_samples;

  always_comb begin
    state_nx = state;
    cfg_nx   = cfg;
    if (soft_rst) begin
      state_nx = PC_IDLE;
      cfg_nx   = '0;
    end else begin
      unique case (state)
        PC_IDLE: if (run_cmd) state_nx = PC_INIT;
        PC_INIT: if (first_samples) begin
          state_nx = PC_DECODE;
          cfg_nx   = '{play: play_bit, mute: mute_bit};
        end
        PC_DECODE: cfg_nx = '{play: play_bit, mute: mute_bit};
        default: state_nx = PC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PC_IDLE;
      cfg   <= '0;
    end else begin
      state <= state_nx;
      cfg   <= cfg_nx;
    end
  end

endmodule

// File: rtl/playctl_outmap.sv
module playctl_outmap
  import playctl_pkg::*;
(
  input  pc_state_e state,
  input  pc_cfg_t   cfg,
  output logic      oclk_en,
  output logic      dec_en,
  output logic      pcm_zero
);

  logic in_decode;
  assign in_decode = (state == PC_DECODE);

  always_comb begin
    if (in_decode) begin
      oclk_en  = pc_clk_run(cfg);
      dec_en   = pc_decoding(cfg);
      pcm_zero = pc_silence(cfg);
    end else begin
      oclk_en  = 1'b0;
      dec_en   = 1'b0;
      pcm_zero = 1'b1;
    end
  end

endmodule

// File: rtl/playctl_reqgen.sv
module playctl_reqgen #(
  parameter int LVL_W     = 8,
  parameter int LOW_MARK  = 64,
  parameter int HIGH_MARK = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] buf_level,
  input  logic             req_pol,
  output logic             req_active,
  output logic             data_req
);

  localparam logic [LVL_W-1:0] LO_L = LVL_W'(LOW_MARK);
  localparam logic [LVL_W-1:0] HI_L = LVL_W'(HIGH_MARK);

  function automatic logic hyst_next(logic cur, logic [LVL_W-1:0] lvl);
    if (lvl < LO_L)      return 1'b1;
    else if (lvl > HI_L) return 1'b0;
    else                 return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_active <= 1'b0;
    else        req_active <= hyst_next(req_active, buf_level);
  end

  assign data_req = req_pol ? req_active : !req_active;

endmodule

// File: rtl/playctl_top.sv
module playctl_top
  import playctl_pkg::*;
#(
  parameter int LVL_W     = 8,
  parameter int LOW_MARK  = 64,
  parameter int HIGH_MARK = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             run_cmd,
  input  logic             first_samples,
  input  logic             play_bit,
  input  logic             mute_bit,
  input  logic [LVL_W-1:0] buf_level,
  input  logic             req_pol,
  output logic [1:0]       state_o,
  output logic             oclk_en,
  output logic             dec_en,
  output logic             pcm_zero,
  output logic             data_req
);

  pc_state_e state;
  pc_cfg_t   cfg;
  logic      enter_init;
  logic      enter_decode;
  logic      req_active;

  playctl_seq seq_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run_cmd(run_cmd),
    .first_samples(first_samples), .play_bit(play_bit), .mute_bit(mute_bit),
    .state(state), .cfg(cfg), .enter_init(enter_init), .enter_decode(enter_decode)
  );

  playctl_outmap map_i (
    .state(state), .cfg(cfg),
    .oclk_en(oclk_en), .dec_en(dec_en), .pcm_zero(pcm_zero)
  );

  playctl_reqgen #(.LVL_W(LVL_W), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) req_i (
    .clk(clk), .rst_n(rst_n), .buf_level(buf_level), .req_pol(req_pol),
    .req_active(req_active), .data_req(data_req)
  );

  assign state_o = state;

endmodule

// File: rtl/playctl_chk.sv
module playctl_chk #(
  parameter int LVL_W     = 8,
  parameter int LOW_MARK  = 64,
  parameter int HIGH_MARK = 192
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             run_cmd,
  input logic             first_samples,
  input logic             play_bit,
  input logic             mute_bit,
  input logic [LVL_W-1:0] buf_level,
  input logic [1:0]       state_o,
  input logic             oclk_en,
  input logic             dec_en,
  input logic             pcm_zero,
  input logic             req_active,
  input logic             enter_init,
  input logic             enter_decode
);

  localparam logic [LVL_W-1:0] LO_L = LVL_W'(LOW_MARK);
  localparam logic [LVL_W-1:0] HI_L = LVL_W'(HIGH_MARK);

  // R1
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && !run_cmd && !soft_rst) |=> state_o == 2'd0);

  // R2
  run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_init |=> state_o == 2'd1);

  // R3
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && !first_samples && !soft_rst) |=> state_o == 2'd1);

  // R4
  quiet_outside_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd2) |-> (!oclk_en && !dec_en && pcm_zero));

  // R5
  latch_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_decode |=> (state_o == 2'd2 && dec_en == $past(play_bit)
                      && oclk_en == ($past(play_bit) || $past(mute_bit))));

  // R6
  dec_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> oclk_en);

  // R6
  pcm_needs_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_zero |-> dec_en);

  // R7
  decode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && !soft_rst) |=>
      (pcm_zero == !($past(play_bit) && !$past(mute_bit))));

  // R8
  soft_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> state_o == 2'd0);

  // R9
  req_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_level < LO_L) |=> req_active);

  // R9
  req_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_level > HI_L) |=> !req_active);

  // R11
  decode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && !soft_rst) |=> state_o == 2'd2);

endmodule

bind playctl_top playctl_chk #(.LVL_W(LVL_W), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) chk_i (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run_cmd(run_cmd),
  .first_samples(first_samples), .play_bit(play_bit), .mute_bit(mute_bit),
  .buf_level(buf_level), .state_o(state_o), .oclk_en(oclk_en), .dec_en(dec_en),
  .pcm_zero(pcm_zero), .req_active(req_active), .enter_init(enter_init),
  .enter_decode(enter_decode)
);

// File: tb/playctl_top_tb_top.sv
module playctl_top_tb_top;

  localparam int LVL_W = 8;
  localparam int LO = 64;
  localparam int HI = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, run_cmd = 1'b0, first_samples = 1'b0;
  logic play_bit = 1'b0, mute_bit = 1'b0, req_pol = 1'b1;
  logic [LVL_W-1:0] buf_level = 8'd128;
  logic [1:0] state_o;
  logic oclk_en, dec_en, pcm_zero, data_req;

  always #2.5 clk = ~clk;

  playctl_top #(.LVL_W(LVL_W), .LOW_MARK(LO), .HIGH_MARK(HI)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run_cmd(run_cmd),
    .first_samples(first_samples), .play_bit(play_bit), .mute_bit(mute_bit),
    .buf_level(buf_level), .req_pol(req_pol), .state_o(state_o),
    .oclk_en(oclk_en), .dec_en(dec_en), .pcm_zero(pcm_zero), .data_req(data_req)
  );

  typedef struct {
    logic [1:0] st;
    logic oclk, dec, zero, req;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [1:0] m_st = 2'd0;
  logic m_play = 1'b0, m_mute = 1'b0, m_req = 1'b0;

  task automatic compare(exp_t e);
    n_run++;
    if (state_o !== e.st || oclk_en !== e.oclk || dec_en !== e.dec ||
        pcm_zero !== e.zero || data_req !== e.req) begin
      n_fail++;
      $display("FAIL %s: got st=%0d clk=%b dec=%b zero=%b req=%b exp st=%0d clk=%b dec=%b zero=%b req=%b",
               e.tag, state_o, oclk_en, dec_en, pcm_zero, data_req,
               e.st, e.oclk, e.dec, e.zero, e.req);
    end
  endtask

  function automatic exp_t expect_now(string tag);
    exp_t e;
    bit dcd;
    dcd = (m_st == 2'd2);
    e.st   = m_st;
    e.oclk = dcd && (m_play || m_mute);
    e.dec  = dcd && m_play;
    e.zero = !(dcd && m_play && !m_mute);
    e.req  = req_pol ? m_req : !m_req;
    e.tag  = tag;
    return e;
  endfunction

  // driver: apply inputs at negedge, advance model, push expectation for next edge
  task automatic cyc(bit sr, bit run, bit fs, bit p, bit m, int lvl, bit pol, string tag);
    @(negedge clk);
    soft_rst = sr; run_cmd = run; first_samples = fs;
    play_bit = p; mute_bit = m; buf_level = LVL_W'(lvl); req_pol = pol;
    if (sr) begin
      m_st = 2'd0; m_play = 1'b0; m_mute = 1'b0;
    end else begin
      case (m_st)
        2'd0: if (run) m_st = 2'd1;
        2'd1: if (fs) begin m_st = 2'd2; m_play = p; m_mute = m; end
        default: begin m_play = p; m_mute = m; end
      endcase
    end
    if (lvl < LO) m_req = 1'b1;
    else if (lvl > HI) m_req = 1'b0;
    sb_q.push_back(expect_now(tag));
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) compare(sb_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state (pol=1, request inactive -> data_req 0)
    compare(expect_now("R1 reset"));
    req_pol = 1'b0; #0.1;
    compare(expect_now("R1 reset pol0"));
    req_pol = 1'b1;
    @(negedge clk); rst_n = 1'b1;

    // R2 idle holds, R4 PLAY/MUTE no effect in idle
    cyc(0,0,0,1,0,128,1,"R2 idle hold");
    cyc(0,0,1,1,1,128,1,"R4 idle quiet");
    cyc(0,1,0,1,0,128,1,"R2 run to init");
    // R3/R4/R5 init holds, toggles ignored
    cyc(0,0,0,1,0,128,1,"R5 init toggle a");
    cyc(0,0,0,0,1,128,1,"R5 init toggle b");
    cyc(0,1,0,1,1,128,1,"R4 init quiet");
    cyc(0,0,1,1,0,128,1,"R3 R5 enter decode play");
    // R6/R7 truth table rows
    cyc(0,0,0,0,0,128,1,"R6 row 00");
    cyc(0,0,0,0,1,128,1,"R6 row 01");
    cyc(0,0,0,1,1,128,1,"R6 row 11");
    cyc(0,0,0,1,0,128,1,"R7 row 10");
    // R11 run/first_samples ignored in decode
    cyc(0,1,1,1,0,128,1,"R11 decode hold");
    // R8 soft reset from decode
    cyc(1,0,0,1,0,128,1,"R8 soft from decode");
    cyc(0,1,0,0,0,128,1,"R8 rerun");
    cyc(0,0,0,1,1,128,1,"R5 init toggle c");
    cyc(0,0,1,0,1,128,1,"R5 enter decode mute");
    cyc(0,0,0,0,1,128,1,"R6 mute only");
    // R8 soft reset from init and idle
    cyc(1,0,0,0,0,128,1,"R8 soft from decode 2");
    cyc(0,1,0,0,0,128,1,"R2 run again");
    cyc(1,0,1,1,0,128,1,"R8 soft from init");
    cyc(1,1,0,0,0,128,1,"R8 soft beats run");
    // R9 hysteresis
    cyc(0,0,0,0,0,10,1,"R9 below low");
    cyc(0,0,0,0,0,100,1,"R9 mid hold on");
    cyc(0,0,0,0,0,HI,1,"R9 at high hold");
    cyc(0,0,0,0,0,HI+1,1,"R9 above high");
    cyc(0,0,0,0,0,150,1,"R9 mid hold off");
    cyc(0,0,0,0,0,LO,1,"R9 at low hold");
    cyc(0,0,0,0,0,LO-1,1,"R9 just below low");
    // R10 polarity
    cyc(0,0,0,0,0,100,0,"R10 pol low active");
    cyc(0,0,0,0,0,250,0,"R10 pol low idle");
    cyc(0,0,0,0,0,250,1,"R10 pol high idle");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule